// File: doc/BRIEF.md
# Demon-Coupled Ising Plane Updater

This block runs a microcanonical Monte Carlo sweep over a cubic Ising spin-glass lattice of edge L with periodic wrap-around. There is no random source. Each site owns a small, bounded energy reservoir (its demon). A spin flips when the reservoir can absorb the energy released, or can pay for the energy needed, without leaving the range 0..DCAP. Two replicas that share one set of couplings are kept as two interleaved lattices, named P and Q. Every neighbour of a P site is a Q site, and every neighbour of a Q site is a P site. One whole lattice can therefore be updated while the other acts as a frozen neighbourhood.

Spins, couplings and demons live in on-chip registers. Software-side logic fills them through a single write port while the block is idle, then pulses `start`. The block updates one z-plane of L×L sites per cycle, first across P and then across Q, so one sweep takes 2L cycles. A one-cycle `done` pulse closes the sweep. Any site can be read back combinationally, and the total energy (bond energy of both replicas plus twice the demon sum) is always visible.

Top module: `demon_spin_engine`

## Requirements
- R1: After reset every spin reads 0 (value −1), every coupling reads 3'b000 (all −1), every demon reads 0, `busy` and `done` are low, and `totalEnergy` equals 6·L³.
- R2: With `busy` low, `loadWe` writes `loadData` at site `loadAddr`, selected by `loadKind`: 0 = P spin (bit 0), 1 = Q spin (bit 0), 2 = P demon, 3 = Q demon, 4 = couplings (bit 0 = +x bond, bit 1 = +y bond, bit 2 = +z bond, where 1 means +1). A demon value above DCAP is stored as DCAP. Site index = x + L·y + L²·z.
- R3: A demon never holds more than DCAP. An update whose energy gain would push the demon above DCAP is rejected, and the spin keeps its value.
- R4: Let σ be ±1 for the spin and h be the local field. The cost is c = σ·h, in units of 2. The spin flips and the demon becomes d − c exactly when 0 ≤ d − c ≤ DCAP. Otherwise the spin and the demon are unchanged.
- R5: The local field of a site is the sum over its six periodic neighbours of J·σ. The neighbour spins come from the other lattice. The −x/−y/−z bonds are the neighbour's +x/+y/+z couplings.
- R6: `start` while idle raises `busy` on the next cycle. P planes 0..L−1 and then Q planes 0..L−1 are updated at one plane per cycle. `done` is high for exactly one cycle, together with `busy` falling, 2L cycles after `busy` rose.
- R7: `totalEnergy` is unchanged by every plane update.
- R8: `loadWe` and `start` have no effect while `busy` is high.
- R9: Sites outside the plane being updated keep their spin and demon. The lattice that is not being updated keeps all its spins and demons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one P-then-Q sweep |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| loadWe | input | 1 | Write strobe for the load port |
| loadKind | input | 3 | Target selector (see R2) |
| loadAddr | input | AW | Site index |
| loadData | input | DW | Spin bit, demon value or coupling bits |
| rdAddr | input | AW | Readback site index |
| rdSpinP | output | 1 | P spin at rdAddr |
| rdSpinQ | output | 1 | Q spin at rdAddr |
| rdDemP | output | DW | P demon at rdAddr |
| rdDemQ | output | DW | Q demon at rdAddr |
| rdCoup | output | 3 | Couplings at rdAddr |
| totalEnergy | output | EW | Signed lattice energy plus twice the demon sum |

## Verification
Two functions of this block can fall in the same cycle: a plane update and an attempt to write the register file or to restart the sweep. The bench provokes this by pulsing `loadWe` (flipping P spin 0) together with `start` in the third cycle of a sweep. It then judges the outcome by comparing every site against a reference model that never applied that write, and by confirming that the sweep length and the single `done` pulse are unaffected. Energy constancy is sampled after every plane and checked against the energy the bench computes before the sweep.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

  typedef enum logic [2:0] {
    LD_SPIN_P = 3'd0,
    LD_SPIN_Q = 3'd1,
    LD_DEM_P  = 3'd2,
    LD_DEM_Q  = 3'd3,
    LD_COUP   = 3'd4
  } ldKind_e;

  typedef struct packed {
    logic updEn;
    logic latQ;
  } stepStrobe_t;

  function automatic int wrapAdd(input int v, input int d, input int n);
    return (v + d + n) % n;
  endfunction

  function automatic int siteOf(input int x, input int y, input int z, input int n);
    return x + n * y + n * n * z;
  endfunction

endpackage

// File: rtl/dsu_site_engine.sv
module dsu_site_engine #(
  parameter int DW   = 4,
  parameter int DCAP = 10
) (
  input  logic          selfSpin,
  input  logic [DW-1:0] selfDem,
  input  logic [5:0]    prodUp,
  output logic          nxtSpin,
  output logic [DW-1:0] nxtDem
);

  logic signed [4:0]    field;
  logic signed [4:0]    cost;
  logic signed [DW+2:0] trial;
  logic                 flipOk;

  always_comb begin
    field   = 5'($countones(prodUp) * 2 - 6);
    cost    = selfSpin ? field : -field;
    trial   = signed'({3'b000, selfDem}) - (DW+3)'(cost);
    flipOk  = (trial >= 0) && (trial <= DCAP);
    nxtSpin = flipOk ? ~selfSpin : selfSpin;
    nxtDem  = flipOk ? trial[DW-1:0] : selfDem;
  end

endmodule

// File: rtl/dsu_seq_ctrl.sv
module dsu_seq_ctrl
  import dsu_pkg::*;
#(
  parameter int L = 4,
  localparam int PW = $clog2(L),
  localparam int CW = $clog2(2 * L)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output stepStrobe_t   strobe,
  output logic [PW-1:0] planeIdx,
  output logic          busy,
  output logic          done
);

  localparam logic [CW-1:0] LAST = CW'(2 * L - 1);
  localparam logic [CW-1:0] HALF = CW'(L);

  typedef enum logic {S_IDLE, S_RUN} seqState_e;

  seqState_e     state;
  logic [CW-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_RUN;
          stepCnt <= '0;
        end
        S_RUN: begin
          if (stepCnt == LAST) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = (state == S_RUN);
    strobe.updEn = busy;
    strobe.latQ  = (stepCnt >= HALF);
    planeIdx     = strobe.latQ ? PW'(stepCnt - HALF) : PW'(stepCnt);
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_start_launch_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && stepCnt == '0));
  assert_done_after_run_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  assert_step_advance_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && stepCnt != LAST) |=> (busy && stepCnt == $past(stepCnt) + 1'b1));

endmodule

// File: rtl/dsu_lattice_dp.sv
module dsu_lattice_dp
  import dsu_pkg::*;
#(
  parameter int L    = 4,
  parameter int DW   = 4,
  parameter int DCAP = 10,
  localparam int N  = L * L * L,
  localparam int AW = $clog2(N),
  localparam int PW = $clog2(L),
  localparam int EW = $clog2(6 * N + 4 * N * DCAP + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  stepStrobe_t          strobe,
  input  logic [PW-1:0]        planeIdx,
  input  logic                 loadWe,
  input  logic [2:0]           loadKind,
  input  logic [AW-1:0]        loadAddr,
  input  logic [DW-1:0]        loadData,
  input  logic [AW-1:0]        rdAddr,
  output logic                 rdSpinP,
  output logic                 rdSpinQ,
  output logic [DW-1:0]        rdDemP,
  output logic [DW-1:0]        rdDemQ,
  output logic [2:0]           rdCoup,
  output logic signed [EW-1:0] totalEnergy
);

  localparam int PLANE = L * L;

  logic          spinP [N];
  logic          spinQ [N];
  logic [DW-1:0] demP  [N];
  logic [DW-1:0] demQ  [N];
  logic [2:0]    coup  [N];

  logic          nxtSpin [PLANE];
  logic [DW-1:0] nxtDem  [PLANE];
  logic [AW-1:0] tgtIdx  [PLANE];

  logic [DW-1:0] loadDem;
  assign loadDem = (int'(loadData) > DCAP) ? DW'(DCAP) : loadData;

  for (genvar gy = 0; gy < L; gy++) begin : g_row
    for (genvar gx = 0; gx < L; gx++) begin : g_col
      logic          selfSpin;
      logic [DW-1:0] selfDem;
      logic [5:0]    prodUp;
      logic [AW-1:0] sIdx;

      always_comb begin
        int z;
        int nb [6];
        logic jv [6];
        z     = int'(planeIdx);
        sIdx  = AW'(siteOf(gx, gy, z, L));
        nb[0] = siteOf(wrapAdd(gx, 1, L), gy, z, L);
        nb[1] = siteOf(wrapAdd(gx, -1, L), gy, z, L);
        nb[2] = siteOf(gx, wrapAdd(gy, 1, L), z, L);
        nb[3] = siteOf(gx, wrapAdd(gy, -1, L), z, L);
        nb[4] = siteOf(gx, gy, wrapAdd(z, 1, L), L);
        nb[5] = siteOf(gx, gy, wrapAdd(z, -1, L), L);
        jv[0] = coup[sIdx][0];
        jv[1] = coup[nb[1]][0];
        jv[2] = coup[sIdx][1];
        jv[3] = coup[nb[3]][1];
        jv[4] = coup[sIdx][2];
        jv[5] = coup[nb[5]][2];
        for (int d = 0; d < 6; d++) begin
          prodUp[d] = ~(jv[d] ^ (strobe.latQ ? spinP[nb[d]] : spinQ[nb[d]]));
        end
        selfSpin = strobe.latQ ? spinQ[sIdx] : spinP[sIdx];
        selfDem  = strobe.latQ ? demQ[sIdx]  : demP[sIdx];
      end

      dsu_site_engine #(.DW(DW), .DCAP(DCAP)) i_engine (
        .selfSpin (selfSpin),
        .selfDem  (selfDem),
        .prodUp   (prodUp),
        .nxtSpin  (nxtSpin[gx + L * gy]),
        .nxtDem   (nxtDem[gx + L * gy])
      );

      assign tgtIdx[gx + L * gy] = sIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < N; s++) begin
        spinP[s] <= 1'b0;
        spinQ[s] <= 1'b0;
        demP[s]  <= '0;
        demQ[s]  <= '0;
        coup[s]  <= 3'b000;
      end
    end else if (strobe.updEn) begin
      for (int k = 0; k < PLANE; k++) begin
        if (strobe.latQ) begin
          spinQ[tgtIdx[k]] <= nxtSpin[k];
          demQ[tgtIdx[k]]  <= nxtDem[k];
        end else begin
          spinP[tgtIdx[k]] <= nxtSpin[k];
          demP[tgtIdx[k]]  <= nxtDem[k];
        end
      end
    end else if (loadWe) begin
      case (ldKind_e'(loadKind))
        LD_SPIN_P: spinP[loadAddr] <= loadData[0];
        LD_SPIN_Q: spinQ[loadAddr] <= loadData[0];
        LD_DEM_P:  demP[loadAddr]  <= loadDem;
        LD_DEM_Q:  demQ[loadAddr]  <= loadDem;
        LD_COUP:   coup[loadAddr]  <= loadData[2:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdSpinP = spinP[rdAddr];
    rdSpinQ = spinQ[rdAddr];
    rdDemP  = demP[rdAddr];
    rdDemQ  = demQ[rdAddr];
    rdCoup  = coup[rdAddr];
  end

  always_comb begin
    int acc;
    acc = 0;
    for (int s = 0; s < N; s++) begin
      int x, y, z, n, j, p, q, pn, qn;
      x = s % L;
      y = (s / L) % L;
      z = s / (L * L);
      p = spinP[s] ? 1 : -1;
      q = spinQ[s] ? 1 : -1;
      for (int d = 0; d < 3; d++) begin
        n  = (d == 0) ? siteOf(wrapAdd(x, 1, L), y, z, L) :
             (d == 1) ? siteOf(x, wrapAdd(y, 1, L), z, L) :
                        siteOf(x, y, wrapAdd(z, 1, L), L);
        j  = coup[s][d] ? 1 : -1;
        pn = spinP[n] ? 1 : -1;
        qn = spinQ[n] ? 1 : -1;
        acc = acc - j * (p * qn + q * pn);
      end
      acc = acc + 2 * (int'(demP[s]) + int'(demQ[s]));
    end
    totalEnergy = EW'(acc);
  end

  assert_energy_conserved_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.updEn |=> (totalEnergy == $past(totalEnergy)));

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_demon_cap_R3: assert property (@(posedge clk) disable iff (rst)
      (int'(demP[g]) <= DCAP) && (int'(demQ[g]) <= DCAP));
    assert_p_site_stable_R9: assert property (@(posedge clk) disable iff (rst)
      (strobe.updEn && (strobe.latQ || planeIdx != PW'(g / PLANE)))
      |=> ($stable(spinP[g]) && $stable(demP[g])));
    assert_q_site_stable_R9: assert property (@(posedge clk) disable iff (rst)
      (strobe.updEn && (!strobe.latQ || planeIdx != PW'(g / PLANE)))
      |=> ($stable(spinQ[g]) && $stable(demQ[g])));
  end

endmodule

// File: rtl/demon_spin_engine.sv
module demon_spin_engine
  import dsu_pkg::*;
#(
  parameter int L    = 4,
  parameter int DW   = 4,
  parameter int DCAP = 10,
  localparam int N  = L * L * L,
  localparam int AW = $clog2(N),
  localparam int PW = $clog2(L),
  localparam int EW = $clog2(6 * N + 4 * N * DCAP + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  input  logic                 loadWe,
  input  logic [2:0]           loadKind,
  input  logic [AW-1:0]        loadAddr,
  input  logic [DW-1:0]        loadData,
  input  logic [AW-1:0]        rdAddr,
  output logic                 rdSpinP,
  output logic                 rdSpinQ,
  output logic [DW-1:0]        rdDemP,
  output logic [DW-1:0]        rdDemQ,
  output logic [2:0]           rdCoup,
  output logic signed [EW-1:0] totalEnergy
);

  stepStrobe_t   strobe;
  logic [PW-1:0] planeIdx;

  dsu_seq_ctrl #(.L(L)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .strobe   (strobe),
    .planeIdx (planeIdx),
    .busy     (busy),
    .done     (done)
  );

  dsu_lattice_dp #(.L(L), .DW(DW), .DCAP(DCAP)) i_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .planeIdx    (planeIdx),
    .loadWe      (loadWe),
    .loadKind    (loadKind),
    .loadAddr    (loadAddr),
    .loadData    (loadData),
    .rdAddr      (rdAddr),
    .rdSpinP     (rdSpinP),
    .rdSpinQ     (rdSpinQ),
    .rdDemP      (rdDemP),
    .rdDemQ      (rdDemQ),
    .rdCoup      (rdCoup),
    .totalEnergy (totalEnergy)
  );

endmodule

// File: tb/test_demon_spin_engine.sv
module test_demon_spin_engine;

  localparam int L    = 4;
  localparam int DW   = 4;
  localparam int DCAP = 10;
  localparam int N    = L * L * L;
  localparam int AW   = $clog2(N);
  localparam int EW   = $clog2(6 * N + 4 * N * DCAP + 1) + 1;

  // vector: [12] spin, [11:8] demon, [7:5] aligned neighbours k, [4] exp spin, [3:0] exp demon
  localparam logic [12:0] VEC [9] = '{
    {1'b1, 4'd0, 3'd0, 1'b0, 4'd6},
    {1'b1, 4'd5, 3'd0, 1'b1, 4'd5},
    {1'b1, 4'd4, 3'd0, 1'b0, 4'd10},
    {1'b1, 4'd0, 3'd3, 1'b0, 4'd0},
    {1'b1, 4'd3, 3'd6, 1'b1, 4'd3},
    {1'b1, 4'd6, 3'd6, 1'b0, 4'd0},
    {1'b0, 4'd2, 3'd2, 1'b1, 4'd0},
    {1'b0, 4'd1, 3'd2, 1'b0, 4'd1},
    {1'b0, 4'd0, 3'd6, 1'b1, 4'd6}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic loadWe = 1'b0;
  logic [2:0] loadKind = '0;
  logic [AW-1:0] loadAddr = '0;
  logic [DW-1:0] loadData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic busy, done, rdSpinP, rdSpinQ;
  logic [DW-1:0] rdDemP, rdDemQ;
  logic [2:0] rdCoup;
  logic signed [EW-1:0] totalEnergy;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  bit rP [N];
  bit rQ [N];
  int rDP [N];
  int rDQ [N];
  bit rJ [N][3];

  always #4 clk = ~clk;

  demon_spin_engine #(.L(L), .DW(DW), .DCAP(DCAP)) i_demon_spin_engine (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .loadWe(loadWe), .loadKind(loadKind), .loadAddr(loadAddr), .loadData(loadData),
    .rdAddr(rdAddr), .rdSpinP(rdSpinP), .rdSpinQ(rdSpinQ), .rdDemP(rdDemP),
    .rdDemQ(rdDemQ), .rdCoup(rdCoup), .totalEnergy(totalEnergy)
  );

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nbOf(input int s, input int d);
    int x, y, z;
    x = s % L; y = (s / L) % L; z = s / (L * L);
    case (d)
      0: x = (x + 1) % L;
      1: x = (x + L - 1) % L;
      2: y = (y + 1) % L;
      3: y = (y + L - 1) % L;
      4: z = (z + 1) % L;
      default: z = (z + L - 1) % L;
    endcase
    return x + L * y + L * L * z;
  endfunction

  function automatic int jOf(input int s, input int d);
    bit b;
    b = (d % 2 == 0) ? rJ[s][d / 2] : rJ[nbOf(s, d)][d / 2];
    return b ? 1 : -1;
  endfunction

  function automatic int refEnergy();
    int e;
    e = 0;
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < 6; d += 2) begin
        int n;
        n = nbOf(s, d);
        e -= jOf(s, d) * ((rP[s] ? 1 : -1) * (rQ[n] ? 1 : -1) + (rQ[s] ? 1 : -1) * (rP[n] ? 1 : -1));
      end
      e += 2 * (rDP[s] + rDQ[s]);
    end
    return e;
  endfunction

  task automatic refSweep();
    for (int lat = 0; lat < 2; lat++) begin
      for (int s = 0; s < N; s++) begin
        int h, sg, c, nd;
        h = 0;
        for (int d = 0; d < 6; d++) begin
          int n;
          n = nbOf(s, d);
          h += jOf(s, d) * (((lat == 0) ? rQ[n] : rP[n]) ? 1 : -1);
        end
        sg = ((lat == 0) ? rP[s] : rQ[s]) ? 1 : -1;
        c = sg * h;
        nd = ((lat == 0) ? rDP[s] : rDQ[s]) - c;
        if (nd >= 0 && nd <= DCAP) begin
          if (lat == 0) begin rP[s] = !rP[s]; rDP[s] = nd; end
          else          begin rQ[s] = !rQ[s]; rDQ[s] = nd; end
        end
      end
    end
  endtask

  task automatic clearRef();
    for (int s = 0; s < N; s++) begin
      rP[s] = 0; rQ[s] = 0; rDP[s] = 0; rDQ[s] = 0;
      rJ[s][0] = 0; rJ[s][1] = 0; rJ[s][2] = 0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clearRef();
  endtask

  task automatic doLoad(input int kind, input int addr, input int data);
    @(negedge clk);
    loadWe = 1'b1; loadKind = 3'(kind); loadAddr = AW'(addr); loadData = DW'(data);
    @(negedge clk);
    loadWe = 1'b0;
  endtask

  task automatic pushAll();
    for (int s = 0; s < N; s++) begin
      doLoad(0, s, int'(rP[s]));
      doLoad(1, s, int'(rQ[s]));
      doLoad(2, s, rDP[s]);
      doLoad(3, s, rDQ[s]);
      doLoad(4, s, int'({rJ[s][2], rJ[s][1], rJ[s][0]}));
    end
  endtask

  function automatic int nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'(lfsr[15:0]);
  endfunction

  task automatic runSweep(input bit inject);
    int e0;
    e0 = refEnergy();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R6", "busy after start", int'({busy, done}), 2);
    check(totalEnergy == EW'(e0), "R7", "energy at sweep begin", int'(totalEnergy), e0);
    for (int n = 2; n <= 2 * L + 1; n++) begin
      @(negedge clk);
      if (inject && n == 3) begin
        loadWe = 1'b1; loadKind = 3'd0; loadAddr = '0; loadData = DW'(!rP[0]); start = 1'b1;
      end
      if (inject && n == 4) begin
        loadWe = 1'b0; start = 1'b0;
      end
      check(totalEnergy == EW'(e0), "R7", "energy after plane update", int'(totalEnergy), e0);
      if (n < 2 * L + 1)
        check(busy && !done, "R6", "busy/done mid sweep", int'({busy, done}), 2);
      else
        check(!busy && done, "R6", "busy/done at sweep end", int'({busy, done}), 1);
    end
    repeat (2) @(negedge clk);
    check(!busy && !done, inject ? "R8" : "R6", "idle after sweep", int'({busy, done}), 0);
    refSweep();
  endtask

  task automatic compareAll(input string req);
    for (int s = 0; s < N; s++) begin
      rdAddr = AW'(s);
      #1;
      check(rdSpinP == rP[s] && rdSpinQ == rQ[s] && int'(rdDemP) == rDP[s] && int'(rdDemQ) == rDQ[s],
            req, $sformatf("site %0d {sP,sQ,dP,dQ}", s),
            int'({rdSpinP, rdSpinQ, rdDemP, rdDemQ}),
            int'({rP[s], rQ[s], 4'(rDP[s]), 4'(rDQ[s])}));
    end
  endtask

  initial begin
    doReset();
    // R1: reset state
    @(negedge clk);
    check(!busy && !done, "R1", "busy/done after reset", int'({busy, done}), 0);
    check(totalEnergy == EW'(6 * N), "R1", "energy after reset", int'(totalEnergy), 6 * N);
    for (int s = 0; s < N; s += 21) begin
      rdAddr = AW'(s);
      #1;
      check({rdSpinP, rdSpinQ, rdDemP, rdDemQ, rdCoup} == '0, "R1", "site cleared",
            int'({rdSpinP, rdSpinQ, rdDemP, rdDemQ, rdCoup}), 0);
    end

    // R2: load path and demon clipping
    doLoad(2, 5, 15);
    doLoad(3, 5, 7);
    doLoad(4, 5, 5);
    doLoad(1, 5, 1);
    rdAddr = AW'(5);
    #1;
    check(int'(rdDemP) == DCAP, "R2", "demon load clipped to cap", int'(rdDemP), DCAP);
    check(int'(rdDemQ) == 7 && rdCoup == 3'b101 && rdSpinQ && !rdSpinP, "R2", "loaded site 5",
          int'({rdDemQ, rdCoup, rdSpinQ, rdSpinP}), int'({4'd7, 3'b101, 1'b1, 1'b0}));

    // R3 R4 R5: single-site rule vectors at site 0 (neighbours wrap across edges)
    for (int v = 0; v < 9; v++) begin
      doReset();
      for (int s = 0; s < N; s++) begin rJ[s][0] = 1; rJ[s][1] = 1; rJ[s][2] = 1; end
      for (int d = 0; d < 6; d++) rQ[nbOf(0, d)] = (d < int'(VEC[v][7:5]));
      rP[0] = VEC[v][12];
      rDP[0] = int'(VEC[v][11:8]);
      pushAll();
      runSweep(1'b0);
      rdAddr = '0;
      #1;
      check(rdSpinP == VEC[v][4] && rdDemP == VEC[v][3:0], "R4",
            $sformatf("vector %0d site 0 {spin,demon} (R3 cap, R5 field)", v),
            int'({rdSpinP, rdDemP}), int'(VEC[v][4:0]));
      compareAll("R9");
    end

    // R4 R7 R9: random configurations against the model, twice
    for (int r = 0; r < 2; r++) begin
      doReset();
      for (int s = 0; s < N; s++) begin
        rP[s] = nextRand() % 2 == 1;
        rQ[s] = nextRand() % 2 == 1;
        rDP[s] = nextRand() % (DCAP + 1);
        rDQ[s] = nextRand() % (DCAP + 1);
        for (int d = 0; d < 3; d++) rJ[s][d] = nextRand() % 2 == 1;
      end
      pushAll();
      runSweep(1'b0);
      compareAll("R4");
      runSweep(r == 1);
      compareAll(r == 1 ? "R8" : "R9");
    end

    finishRun();
  end

endmodule